// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps a running date and time in packed BCD. The fields are century, two-digit year, month, day of month, weekday, hours, minutes and seconds. A built-in divider turns the input clock into a one-second tick. Each accepted tick moves the seconds forward, and carries ripple upward through minutes, hours and then the calendar. The clock uses the 24-hour convention. The calendar spans the two centuries from 1900 to 2099, with a leap year in every year whose two-digit value is a multiple of four.

Software sets the counter through a shared byte value and a strobe vector with one bit per field, so any single field can be written in any cycle. There are two separate freeze inputs. One stops the time-of-day group and the other stops the calendar group, so the date can be rewritten at leisure while the time keeps running. Single-cycle pulses mark every accepted second and every minute, hour and midnight rollover, for use by an alarm or interrupt stage outside this block.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: While reset is asserted and right after it, the outputs read century 19, year 00, month 01, date 01, weekday 1 and 00:00:00, with all pulses low.
- R2: A tick is produced once every TICK_DIV clock cycles, counted from reset release. While time is not frozen, each tick advances the seconds by one and raises sec_pulse for that one cycle.
- R3: Seconds and minutes count in BCD from 00 to 59 and then wrap to 00 with a carry into the next field. Hours count from 00 to 23 and then wrap to 00.
- R4: The weekday counts 1 to 7, wraps from 7 to 1, and advances only when the date advances.
- R5: The date wraps to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11. Each such wrap advances the month. The month wraps from 12 to 01 and advances the year.
- R6: February has 29 days when the BCD year value is a multiple of four, including 00 in both centuries, and 28 days otherwise.
- R7: The year wraps from 99 to 00 and toggles the century between 19 and 20, so the day after 2099-12-31 is 1900-01-01.
- R8: While time_hold is high, ticks are ignored. Seconds, minutes and hours stay unchanged unless loaded, all four pulses stay low, and no carry reaches the calendar.
- R9: While cal_hold is high, the time group keeps counting and day_pulse still fires at midnight. Weekday, date, month, year and century stay unchanged unless loaded.
- R10: When bit k of ld_en is high, field k takes ld_val at the next edge and counting for that field is overridden in that cycle. No carry leaves a loaded field. The bit order is 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 century. A load works even while that field's group is frozen.
- R11: min_pulse, hour_pulse and day_pulse go high for one cycle, in the same cycle the new field values appear, when the seconds, minutes or hours respectively wrap by counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock, divided by TICK_DIV to form the one-second tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_hold | input | 1 | Freezes hours, minutes and seconds |
| cal_hold | input | 1 | Freezes weekday, date, month, year and century |
| ld_en | input | 8 | Per-field load strobes, bit order as in R10 |
| ld_val | input | 8 | BCD value written into every strobed field |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours 00-23, BCD |
| wday_bcd | output | 8 | Weekday 1-7 |
| mday_bcd | output | 8 | Day of month, BCD |
| mon_bcd | output | 8 | Month 01-12, BCD |
| yr_bcd | output | 8 | Two-digit year, BCD |
| cent_bcd | output | 8 | Century, 19 or 20 in BCD |
| sec_pulse | output | 1 | One cycle per accepted tick |
| min_pulse | output | 1 | One cycle at each seconds rollover |
| hour_pulse | output | 1 | One cycle at each minutes rollover |
| day_pulse | output | 1 | One cycle at each midnight |

## Verification
A free run of just over an hour from reset exercises every seconds and minutes value and shows whether the carries land at 59 and not at a binary limit. A sweep covers every year of both centuries at the end of February, and separates the multiple-of-four rule from any century exception, since 1900 and 2000 must behave alike. A month-by-month sweep in a leap year and in a common year checks each month length and the year-end wrap. Targeted runs freeze each group across midnight, load a field exactly on a tick edge, and cross the 2099 and 1999 year ends, to show that held groups, suppressed carries and the century toggle each behave as stated.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    // Field index inside the time group
    localparam int T_SEC  = 0;
    localparam int T_MIN  = 1;
    localparam int T_HOUR = 2;
    localparam int T_NUM  = 3;

    // Number of calendar fields
    localparam int C_NUM  = 5;

    typedef logic [T_NUM-1:0][7:0] tfields_t;

    typedef struct packed {
        tfields_t f;
        logic     sp;
        logic     mp;
        logic     hp;
        logic     dp;
    } tstate_t;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
    } cfields_t;

    // Increment a two-digit packed BCD value (no range limit applied here)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = v[7:4];
        lo = v[3:0];
        if (lo >= 4'd9) begin
            return {hi + 4'd1, 4'h0};
        end
        return {hi, lo + 4'd1};
    endfunction

    // Year is leap when (10*hi + lo) mod 4 == 0, i.e. (2*hi + lo) mod 4 == 0
    function automatic logic is_leap(input logic [7:0] y);
        logic [1:0] r;
        r = {y[4], 1'b0} + y[1:0];
        return (r == 2'd0);
    endfunction

    // Last day of the month in BCD
    function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
        logic [7:0] n;
        case (m)
            8'h02:                      n = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: n = 8'h30;
            default:                    n = 8'h31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        if (cnt_q >= LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = (cnt_q == LAST);

    // R2: after a tick the divider restarts from zero
    a_r2_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

    // R2: the counter never leaves its range
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic [2:0] ld_en,
    input  logic [7:0] ld_val,
    output tstate_t    st,
    output logic       day_carry
);
    localparam logic [7:0] LIM [T_NUM] = '{8'h59, 8'h59, 8'h23};

    tstate_t    st_d;
    tstate_t    st_q;
    logic [2:0] carries;
    logic       cnt_en;

    always_comb begin
        logic carry;
        logic cout;
        st_d    = st_q;
        cnt_en  = tick && !hold;
        carry   = cnt_en;
        carries = '0;
        for (int i = 0; i < T_NUM; i++) begin
            cout = 1'b0;
            if (ld_en[i]) begin
                st_d.f[i] = ld_val;
            end else if (carry) begin
                if (st_q.f[i] >= LIM[i]) begin
                    st_d.f[i] = 8'h00;
                    cout      = 1'b1;
                end else begin
                    st_d.f[i] = bcd_inc(st_q.f[i]);
                end
            end
            carries[i] = cout;
            carry      = cout;
        end
        st_d.sp = cnt_en;
        st_d.mp = carries[T_SEC];
        st_d.hp = carries[T_MIN];
        st_d.dp = carries[T_HOUR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st        = st_q;
    assign day_carry = carries[T_HOUR];

    // R8: frozen time group without loads keeps its value and pulses stay low
    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && ld_en == 3'b000) |=> ($stable(st_q.f) && !st_q.sp && !st_q.dp));

    // R3: counted seconds at 59 wrap to 00
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold && !ld_en[T_SEC] && st_q.f[T_SEC] == 8'h59) |=> (st_q.f[T_SEC] == 8'h00));

    // R11: rollover pulses coincide with zeroed lower fields
    a_r11_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mp |-> (st_q.f[T_SEC] == 8'h00 && st_q.sp));
    a_r11_day_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dp |-> (st_q.f == '0 && st_q.hp && st_q.mp));

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             day_carry,
    input  logic             hold,
    input  logic [C_NUM-1:0] ld_en,
    input  logic [7:0]       ld_val,
    output cfields_t         cal
);
    localparam cfields_t RST_VAL = '{cent: 8'h19, year: 8'h00, month: 8'h01,
                                     date: 8'h01, dow: 8'h01};

    cfields_t   cal_d;
    cfields_t   cal_q;
    logic       inc;
    logic       mon_carry;
    logic       yr_carry;
    logic       cent_carry;
    logic [7:0] last_day;

    always_comb begin
        cal_d      = cal_q;
        inc        = day_carry && !hold;
        mon_carry  = 1'b0;
        yr_carry   = 1'b0;
        cent_carry = 1'b0;
        last_day   = month_len(cal_q.month, is_leap(cal_q.year));

        // weekday
        if (ld_en[0]) begin
            cal_d.dow = ld_val;
        end else if (inc) begin
            cal_d.dow = (cal_q.dow >= 8'h07) ? 8'h01 : bcd_inc(cal_q.dow);
        end

        // day of month
        if (ld_en[1]) begin
            cal_d.date = ld_val;
        end else if (inc) begin
            if (cal_q.date >= last_day) begin
                cal_d.date = 8'h01;
                mon_carry  = 1'b1;
            end else begin
                cal_d.date = bcd_inc(cal_q.date);
            end
        end

        // month
        if (ld_en[2]) begin
            cal_d.month = ld_val;
        end else if (mon_carry) begin
            if (cal_q.month >= 8'h12) begin
                cal_d.month = 8'h01;
                yr_carry    = 1'b1;
            end else begin
                cal_d.month = bcd_inc(cal_q.month);
            end
        end

        // year
        if (ld_en[3]) begin
            cal_d.year = ld_val;
        end else if (yr_carry) begin
            if (cal_q.year >= 8'h99) begin
                cal_d.year = 8'h00;
                cent_carry = 1'b1;
            end else begin
                cal_d.year = bcd_inc(cal_q.year);
            end
        end

        // century
        if (ld_en[4]) begin
            cal_d.cent = ld_val;
        end else if (cent_carry) begin
            cal_d.cent = (cal_q.cent == 8'h19) ? 8'h20 : 8'h19;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= RST_VAL;
        end else begin
            cal_q <= cal_d;
        end
    end

    assign cal = cal_q;

    // R9: frozen calendar without loads keeps every field
    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && ld_en == '0) |=> $stable(cal_q));

    // R4: weekday 7 wraps to 1 when the date advances
    a_r4_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld_en[0] && cal_q.dow == 8'h07) |=> (cal_q.dow == 8'h01));

    // R5: date leaves a month only by returning to 01
    a_r5_date_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_carry && !ld_en[1]) |=> (cal_q.date == 8'h01));

    // R7: a counted year wrap changes the century
    a_r7_cent_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (cent_carry && !ld_en[4]) |=> (cal_q.cent != $past(cal_q.cent)));

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter int TICK_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       time_hold,
    input  logic       cal_hold,
    input  logic [7:0] ld_en,
    input  logic [7:0] ld_val,
    output logic [7:0] sec_bcd,
    output logic [7:0] min_bcd,
    output logic [7:0] hour_bcd,
    output logic [7:0] wday_bcd,
    output logic [7:0] mday_bcd,
    output logic [7:0] mon_bcd,
    output logic [7:0] yr_bcd,
    output logic [7:0] cent_bcd,
    output logic       sec_pulse,
    output logic       min_pulse,
    output logic       hour_pulse,
    output logic       day_pulse
);
    logic     tick;
    logic     day_carry;
    tstate_t  tst;
    cfields_t cal;

    rtc_sec_divider #(.DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rtc_time_chain u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold      (time_hold),
        .ld_en     (ld_en[T_NUM-1:0]),
        .ld_val    (ld_val),
        .st        (tst),
        .day_carry (day_carry)
    );

    rtc_date_chain u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_carry (day_carry),
        .hold      (cal_hold),
        .ld_en     (ld_en[7:T_NUM]),
        .ld_val    (ld_val),
        .cal       (cal)
    );

    assign sec_bcd    = tst.f[T_SEC];
    assign min_bcd    = tst.f[T_MIN];
    assign hour_bcd   = tst.f[T_HOUR];
    assign sec_pulse  = tst.sp;
    assign min_pulse  = tst.mp;
    assign hour_pulse = tst.hp;
    assign day_pulse  = tst.dp;
    assign wday_bcd   = cal.dow;
    assign mday_bcd   = cal.date;
    assign mon_bcd    = cal.month;
    assign yr_bcd     = cal.year;
    assign cent_bcd   = cal.cent;

    // R9: a midnight under calendar freeze still reports the day pulse
    a_r9_day_pulse_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && cal_hold) |=> day_pulse);

endmodule

// File: tb/sim_rtc_bcd_calendar.sv
module sim_rtc_bcd_calendar;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       time_hold = 1'b0;
    logic       cal_hold = 1'b0;
    logic [7:0] ld_en = 8'h00;
    logic [7:0] ld_val = 8'h00;
    logic [7:0] sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd, yr_bcd, cent_bcd;
    logic       sec_pulse, min_pulse, hour_pulse, day_pulse;

    rtc_bcd_calendar #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .time_hold(time_hold), .cal_hold(cal_hold),
        .ld_en(ld_en), .ld_val(ld_val),
        .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd),
        .wday_bcd(wday_bcd), .mday_bcd(mday_bcd), .mon_bcd(mon_bcd),
        .yr_bcd(yr_bcd), .cent_bcd(cent_bcd),
        .sec_pulse(sec_pulse), .min_pulse(min_pulse),
        .hour_pulse(hour_pulse), .day_pulse(day_pulse)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state (binary integers)
    int ms = 0, mm = 0, mh = 0, mw = 1, md = 1, mmo = 1, my = 0, mc = 19;
    int esp = 0, emp = 0, ehp = 0, edp = 0;
    int pcount = 0, last_pc = 0;
    logic [7:0] cld = 8'h00, cval = 8'h00;
    logic       cth = 1'b0, cch = 1'b0;

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = 4'(v / 10);
        lo = 4'(v % 10);
        return {hi, lo};
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // capture inputs seen at each active edge
    always @(posedge clk) begin
        if (rst_n) begin
            pcount = pcount + 1;
            cld  = ld_en;
            cval = ld_val;
            cth  = time_hold;
            cch  = cal_hold;
        end
    end

    // step the reference model once per edge and compare
    always @(negedge clk) begin
        if (rst_n && pcount != last_pc && !done) begin
            int v;
            int ml;
            bit cnt, c1, c2, c3, dinc, mcar, ycar, ccar;
            string tt, tc, tdate;
            last_pc = pcount;
            v  = b2i(cval);
            ml = mlen(mmo, my);
            tdate = (mmo == 2) ? "R6" : "R5";
            cnt = ((pcount % DIV) == 0) && !cth;
            c1 = 0; c2 = 0; c3 = 0; mcar = 0; ycar = 0; ccar = 0;
            if (cld[0]) ms = v;
            else if (cnt) begin if (ms == 59) begin ms = 0; c1 = 1; end else ms++; end
            if (cld[1]) mm = v;
            else if (c1) begin if (mm == 59) begin mm = 0; c2 = 1; end else mm++; end
            if (cld[2]) mh = v;
            else if (c2) begin if (mh == 23) begin mh = 0; c3 = 1; end else mh++; end
            dinc = c3 && !cch;
            if (cld[3]) mw = v;
            else if (dinc) mw = (mw == 7) ? 1 : mw + 1;
            if (cld[4]) md = v;
            else if (dinc) begin if (md >= ml) begin md = 1; mcar = 1; end else md++; end
            if (cld[5]) mmo = v;
            else if (mcar) begin if (mmo == 12) begin mmo = 1; ycar = 1; end else mmo++; end
            if (cld[6]) my = v;
            else if (ycar) begin if (my == 99) begin my = 0; ccar = 1; end else my++; end
            if (cld[7]) mc = v;
            else if (ccar) mc = (mc == 19) ? 20 : 19;
            esp = cnt; emp = c1; ehp = c2; edp = c3;

            tt = (cld[2:0] != 0) ? "R10" : (cth ? "R8" : "R3");
            tc = (cld[7:3] != 0) ? "R10" : (cch ? "R9" : "");
            chk(tt, "sec",  sec_bcd,  i2b(ms));
            chk(tt, "min",  min_bcd,  i2b(mm));
            chk(tt, "hour", hour_bcd, i2b(mh));
            chk((tc != "") ? tc : "R4",  "wday", wday_bcd, i2b(mw));
            chk((tc != "") ? tc : tdate, "mday", mday_bcd, i2b(md));
            chk((tc != "") ? tc : "R5",  "mon",  mon_bcd,  i2b(mmo));
            chk((tc != "") ? tc : "R7",  "year", yr_bcd,   i2b(my));
            chk((tc != "") ? tc : "R7",  "cent", cent_bcd, i2b(mc));
            chk(cth ? "R8" : "R2", "sec_pulse", {7'd0, sec_pulse}, 8'(esp));
            chk("R11", "min_pulse",  {7'd0, min_pulse},  8'(emp));
            chk("R11", "hour_pulse", {7'd0, hour_pulse}, 8'(ehp));
            chk(cch ? "R9" : "R11", "day_pulse", {7'd0, day_pulse}, 8'(edp));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ldf(input int idx, input int val);
        ld_en  = 8'(1 << idx);
        ld_val = i2b(val);
        @(negedge clk);
        ld_en  = 8'h00;
    endtask

    task automatic set_time(input int h, input int m, input int s);
        ldf(2, h); ldf(1, m); ldf(0, s);
    endtask

    task automatic set_cal(input int c, input int y, input int mo, input int d);
        ldf(7, c); ldf(6, y); ldf(5, mo); ldf(4, d);
    endtask

    task automatic wait_day();
        @(negedge clk);
        while (!day_pulse) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int p0;
        logic [7:0] keep_min, keep_date;

        // R1: reset state
        cyc(3);
        chk("R1", "rst sec",  sec_bcd,  8'h00);
        chk("R1", "rst min",  min_bcd,  8'h00);
        chk("R1", "rst hour", hour_bcd, 8'h00);
        chk("R1", "rst wday", wday_bcd, 8'h01);
        chk("R1", "rst mday", mday_bcd, 8'h01);
        chk("R1", "rst mon",  mon_bcd,  8'h01);
        chk("R1", "rst year", yr_bcd,   8'h00);
        chk("R1", "rst cent", cent_bcd, 8'h19);
        chk("R1", "rst pulses", {4'd0, sec_pulse, min_pulse, hour_pulse, day_pulse}, 8'h00);
        rst_n = 1'b1;

        // R2: spacing of seconds
        @(negedge clk);
        while (!sec_pulse) @(negedge clk);
        p0 = pcount;
        @(negedge clk);
        while (!sec_pulse) @(negedge clk);
        chk("R2", "tick spacing", 8'(pcount - p0), 8'(DIV));

        // R3/R11: free run past one full hour
        cyc(3700 * DIV);

        // R5/R7: year ends in both centuries
        set_cal(19, 99, 12, 31); set_time(23, 59, 59); wait_day();
        set_cal(20, 99, 12, 31); set_time(23, 59, 59); wait_day();
        chk("R7", "2099 wrap cent", cent_bcd, 8'h19);
        chk("R7", "2099 wrap year", yr_bcd, 8'h00);

        // R6: end of February for every year of both centuries
        for (int c = 19; c <= 20; c++) begin
            for (int y = 0; y < 100; y++) begin
                set_cal(c, y, 2, 28);
                set_time(23, 59, 59); wait_day();
                set_time(23, 59, 59); wait_day();
            end
        end

        // R5/R4: month lengths in a common and a leap year
        for (int y = 23; y <= 24; y++) begin
            for (int m = 1; m <= 12; m++) begin
                if (m != 2) begin
                    ldf(6, y); ldf(5, m); ldf(4, 30); ldf(3, 6);
                    set_time(23, 59, 59); wait_day();
                    set_time(23, 59, 59); wait_day();
                end
            end
        end

        // R8: time frozen across a would-be midnight, load still works
        set_time(23, 59, 59);
        time_hold = 1'b1;
        cyc(5 * DIV);
        ldf(1, 30);
        chk("R8", "held min loaded", min_bcd, 8'h30);
        cyc(3 * DIV);
        time_hold = 1'b0;
        cyc(3 * DIV);

        // R9: calendar frozen while time crosses midnight
        ldf(4, 15); ldf(5, 6);
        keep_date = mday_bcd;
        cal_hold = 1'b1;
        set_time(23, 59, 59); wait_day();
        cyc(2);
        chk("R9", "held date", mday_bcd, keep_date);
        chk("R9", "time ran", hour_bcd, 8'h00);
        cal_hold = 1'b0;
        cyc(2 * DIV);

        // R10: load on a tick edge suppresses the carry
        ldf(1, 10);
        while (((pcount + 1) % DIV) != 1) @(negedge clk);
        ldf(0, 59);
        while (((pcount + 1) % DIV) != 0) @(negedge clk);
        keep_min = min_bcd;
        ldf(0, 30);
        chk("R10", "loaded sec on tick", sec_bcd, 8'h30);
        chk("R10", "no carry from load", min_bcd, keep_min);
        cyc(4 * DIV);

        finish_run();
    end

endmodule